// File: doc/BRIEF.md
# Two-Stage Divided PWM Generator

This block produces one pulse-width-modulated output. Software controls it through three registers on a simple single-cycle bus: a control word, a sample (duty) count and a period count. The input clock is slowed in two steps. A 7-bit prescaler divides it by 1 to 128. A power-of-two selector then divides the result by 2, 4, 8 or 16. Each divided tick advances a period counter, and the output stays high while that counter is below the sample count.

The enable bit starts and stops generation. While the block is disabled, both divider stages and the counter are held at zero and the output is low. New period and sample values written during that time are used from the next enable onward.

Top module: `pwm_twostage`

## Requirements
- R1: Byte offset 0x00 is the control register, 0x04 is the sample register and 0x08 is the period register. Each reads back what was last written to it. In the control register, bit 4 is enable, bits 14:8 are the prescaler field and bits 1:0 are the clock-select field. All other control bits read as zero.
- R2: Any other offset reads as zero, and a write to it changes no register.
- R3: After reset, all registers read zero and the output is low.
- R4: When enable is clear, the output is low and the counter and both divider stages are held at zero.
- R5: One counter tick occurs every (P+1)·2^(S+1) input clocks, where P is the prescaler field and S is the clock-select field (S of 0, 1, 2, 3 gives /2, /4, /8, /16).
- R6: The counter runs from 0 up to period−1 and then wraps to 0, so one output cycle lasts period ticks. A period of 0 behaves like a period of 1.
- R7: Counting from the clock edge that sets enable, the output is high while the count is below the sample value. Over one output cycle it is therefore high for min(sample, period) ticks.
- R8: A sample of 0 gives a constant low output. A sample at or above the period gives a constant high output.
- R9: Period and sample values written while disabled take effect when enable is next set, and the count restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is the exact interaction between the two divider stages. A wrong terminal value in either stage, or in the period counter, shifts every pulse edge by a few input clocks, and that error only shows up when the high and low times are measured to the clock. The bench first disables the block, loads new counts, then enables it. It then counts high cycles over exactly one and exactly two output cycles, for every clock-select code, several prescaler values and every sample from 0 to one past the period. A long run at the largest divide checks the far end of the range.

// File: rtl/pwm_twostage.sv
module pwm_twostage #(
  parameter int ADDR_W   = 4,
  parameter int PERIOD_W = 16,
  parameter int PSC_W    = 7,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  localparam int SCNT_W = (1 << SEL_W) + 1;

  logic                ctrl_en;
  logic [PSC_W-1:0]    ctrl_psc;
  logic [SEL_W-1:0]    ctrl_sel;
  logic [PERIOD_W-1:0] sample_q, period_q, cnt;
  logic [PSC_W-1:0]    pre_cnt;
  logic [SCNT_W-1:0]   sel_cnt, sel_lim;
  logic                pre_tick, tick, cnt_wrap;

  wire hit_ctrl   = bus_addr == ADDR_W'(8'h00);
  wire hit_sample = bus_addr == ADDR_W'(8'h04);
  wire hit_period = bus_addr == ADDR_W'(8'h08);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_psc <= '0;
      ctrl_sel <= '0;
      sample_q <= '0;
      period_q <= '0;
    end else if (bus_wr) begin
      if (hit_ctrl) begin
        ctrl_en  <= bus_wdata[4];
        ctrl_psc <= bus_wdata[8 +: PSC_W];
        ctrl_sel <= bus_wdata[SEL_W-1:0];
      end
      if (hit_sample) sample_q <= bus_wdata[PERIOD_W-1:0];
      if (hit_period) period_q <= bus_wdata[PERIOD_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[4]             = ctrl_en;
      bus_rdata[8 +: PSC_W]    = ctrl_psc;
      bus_rdata[SEL_W-1:0]     = ctrl_sel;
    end
    if (hit_sample) bus_rdata[PERIOD_W-1:0] = sample_q;
    if (hit_period) bus_rdata[PERIOD_W-1:0] = period_q;
  end

  assign sel_lim  = (SCNT_W'(2) << ctrl_sel) - SCNT_W'(1);
  assign pre_tick = pre_cnt == ctrl_psc;
  assign tick     = pre_tick && (sel_cnt == sel_lim);
  assign cnt_wrap = {1'b0, cnt} + 1'b1 >= {1'b0, period_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      sel_cnt <= '0;
      cnt     <= '0;
    end else if (!ctrl_en) begin
      pre_cnt <= '0;
      sel_cnt <= '0;
      cnt     <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) sel_cnt <= tick ? '0 : sel_cnt + 1'b1;
      if (tick)     cnt     <= cnt_wrap ? '0 : cnt + 1'b1;
    end
  end

  assign pwm_out = ctrl_en && (cnt < sample_q);

  p_low_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !pwm_out);
  p_cnt_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |=> (cnt == '0 && pre_cnt == '0 && sel_cnt == '0));
  p_tick_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_cnt_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !tick && !bus_wr) |=> $stable(cnt));
  p_zero_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_q == '0) |-> !pwm_out);
endmodule

// File: tb/pwm_twostage_tb_top.sv
module pwm_twostage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_twostage dut_i (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata, .pwm_out);

  task automatic check(string req, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic measure(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctrl(bit en, int psc, int sel);
    return (32'(en) << 4) | (32'(psc) << 8) | 32'(sel);
  endfunction

  task automatic run(int psc, int sel, int per, int smp, string req);
    int d, p, h, h2, expd;
    logic first;
    d = (psc + 1) * (2 << sel);
    p = (per == 0) ? 1 : per;
    wr(4'h0, ctrl(0, psc, sel));
    wr(4'h4, 32'(smp));
    wr(4'h8, 32'(per));
    wr(4'h0, ctrl(1, psc, sel));
    first = pwm_out;
    measure(p * d, h);
    expd = d * ((smp < p) ? smp : p);
    check({req, " R7 one cycle"}, h, expd);
    check({req, " R9 start level"}, first, smp > 0);
    measure(2 * p * d, h2);
    check({req, " R6/R5 two cycles"}, h2, 2 * expd);
    if (smp == 0) check("R8 low", h2, 0);
    if (smp >= p) check("R8 high", h2, 2 * p * d);
  endtask

  initial begin
    logic [31:0] r;
    int h;
    repeat (3) @(negedge clk);
    check("R3 out", pwm_out, 0);
    rd(4'h0, r); check("R3 ctrl", r, 0);
    rd(4'h4, r); check("R3 sample", r, 0);
    rd(4'h8, r); check("R3 period", r, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(4'h0, 32'hFFFF_FFEF);
    rd(4'h0, r); check("R1 ctrl fields", r, 32'h7F03);
    wr(4'h0, 32'h0000_0210);
    rd(4'h0, r); check("R1 ctrl enable", r, 32'h0210);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h1234_ABCD);
    rd(4'h4, r); check("R1 sample", r, 32'hABCD);
    wr(4'h8, 32'h0000_BEEF);
    rd(4'h8, r); check("R1 period", r, 32'hBEEF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, r); check("R2 read zero", r, 0);
    rd(4'h0, r); check("R2 ctrl kept", r, 0);
    rd(4'h4, r); check("R2 sample kept", r, 32'hABCD);
    rd(4'h8, r); check("R2 period kept", r, 32'hBEEF);
    wr(4'h2, 32'h0000_0013);
    rd(4'h0, r); check("R2 ctrl kept 2", r, 0);
    check("R2 out low", pwm_out, 0);

    for (int psc = 0; psc < 3; psc++)
      for (int sel = 0; sel < 4; sel++)
        for (int per = 2; per < 4; per++)
          for (int smp = 0; smp <= per + 1; smp++)
            run(psc, sel, per, smp, "R5 sweep");
    run(1, 0, 0, 1, "R6 period0");
    run(0, 1, 1, 0, "R6 period1");

    wr(4'h4, 32'd1); wr(4'h8, 32'd3); wr(4'h0, ctrl(1, 0, 0));
    wr(4'h0, ctrl(0, 0, 0));
    measure(20, h); check("R4 off low", h, 0);

    run(127, 3, 2, 1, "R5 max divide");

    wr(4'h0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule